// File: doc/BRIEF.md
# GPIO Bank with Atomic Set/Clear Control

This block is a 32-pin general-purpose I/O register file that sits behind a plain 32-bit register bus. Every per-pin control function lives in a register written through a split-word atomic encoding. A 1 in the lower half of the write data sets a pin's bit, and a 1 in the upper half clears it. Software can therefore change one pin without a read-modify-write and without racing other agents that own other pins. The per-pin controls are:

- output value
- output enable
- input enable
- two alternate-output selects
- an alternate-input select

Pins are grouped in two banks of sixteen. The low bank holds pins 0 to 15 and the high bank holds pins 16 to 31. Each bank has its own copy of the register map, and the high copy sits 0x80 above the low one. Besides the control registers, the block gives:

- a synchronised pad-level read-back
- per-pin rising-edge and falling-edge status registers, which are cleared by writing 1s

The pad multiplexer picks what drives each pad: an alternate source, the output value, or nothing. Four pin positions are reserved: they read as zero and ignore every write.

Top module: `gpio_atomic_bank`

## Requirements
- R1: After a synchronous active-low reset, every control bit and every edge-status bit is 0 and every pad enable is 0.
- R2: Bank register offsets are: 0x00 output value, 0x04 output enable, 0x08 input enable, 0x0C alternate-output A select, 0x10 alternate-output B select, 0x14 alternate-input select, 0x18 level read-back, 0x1C rising status, 0x20 falling status. An address below 0x80 selects the low bank (pins 0-15). The same offset plus 0x80 selects the high bank (pins 16-31). Writing 1 to data bit n (0-15) of a control register sets the bit of bank pin n. Data bits that are 0 leave their pins unchanged.
- R3: Writing 1 to data bit n+16 of a control register clears the bit of bank pin n.
- R4: When one write has both bit n and bit n+16 at 1, the bit of bank pin n ends up cleared.
- R5: Pins 23, 29, 30 and 31 are reserved. In every register they read as 0, and writes leave them unchanged. Their pad enables stay 0.
- R6: Each pad is driven according to the first of these rules that applies:
  - alternate-output A select is 1: the pad drives the alternate source A, with the pad enable at 1;
  - alternate-output B select is 1: the pad drives the alternate source B, with the pad enable at 1;
  - output enable is 1: the pad drives the output value, with the pad enable at 1;
  - none of these: the pad enable is 0.
- R7: A register read returns bank pin n at data bit n, and data bits 31:16 read as 0. The level read-back shows each pad input level after a two-flop synchroniser.
- R8: A rising edge sets that pin's rising-status bit, and a falling edge sets that pin's falling-status bit. An edge is seen on the synchronised level and only counts while the pin's input enable is 1.
- R9: In a status register, writing 1 to data bit n clears the status bit of bank pin n. Data bits 31:16 have no effect there.
- R10: The alternate-input output of a pin is its synchronised level ANDed with its input enable and its alternate-input select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| alt_src_a | input | 32 | Alternate-output source A per pin |
| alt_src_b | input | 32 | Alternate-output source B per pin |
| alt_in | output | 32 | Gated synchronised input to alternate consumers |

## Verification
The bench builds the block with its defaults: sixteen-pin banks, the high window at 0x80, and reserved pins 23 and 29-31. These values put both address windows within reach of directed writes. They also place one reserved pin in the middle of the high bank and three at its top. The bench drives set-only, clear-only and combined set-and-clear words, and checks that untouched pins keep their state. It also toggles pad levels with input enable both on and off, and reads the edge status from both banks.

// File: rtl/gpio_pkg.sv
// Package: shared offsets and control-function indices for the GPIO bank.
// Assumes a 4-byte register stride; offsets are relative to a bank window.
package gpio_pkg;
    localparam int FN_OUT_VAL  = 0;
    localparam int FN_OUT_EN   = 1;
    localparam int FN_IN_EN    = 2;
    localparam int FN_ALT_A    = 3;
    localparam int FN_ALT_B    = 4;
    localparam int FN_IN_ALT   = 5;
    localparam int NUM_CTRL    = 6;
    localparam int REG_STRIDE  = 4;
    localparam int OFS_LEVEL   = 'h18;
    localparam int OFS_RISE    = 'h1C;
    localparam int OFS_FALL    = 'h20;
endpackage

// File: rtl/gpio_ctrl_reg.sv
// Module: one per-pin control register covering both banks.
// A bank write sets bits from the low data half and clears bits from the
// high data half; clear wins. Reserved pins never leave 0.
module gpio_ctrl_reg #(
    parameter int          BANK_W   = 16,
    parameter logic [2*BANK_W-1:0] RSV_MASK = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [2*BANK_W-1:0] wdata,
    output logic [2*BANK_W-1:0] q
);
    localparam int NP = 2 * BANK_W;

    // Next state of one bank under the split set/clear encoding
    function automatic logic [BANK_W-1:0] apply_bank(
        input logic [BANK_W-1:0] cur,
        input logic [NP-1:0]     data,
        input logic [BANK_W-1:0] rsv
    );
        return (cur | data[BANK_W-1:0]) & ~data[NP-1:BANK_W] & ~rsv;
    endfunction

    // Register update: reset to 0, then per-bank atomic writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (wr_lo) q[BANK_W-1:0]  <= apply_bank(q[BANK_W-1:0], wdata, RSV_MASK[BANK_W-1:0]);
            if (wr_hi) q[NP-1:BANK_W] <= apply_bank(q[NP-1:BANK_W], wdata, RSV_MASK[NP-1:BANK_W]);
        end
    end
endmodule

// File: rtl/gpio_edge_det.sv
// Module: pad synchroniser and edge-status capture for all pins.
// Two flops synchronise the pad; a third holds the previous level. Edges
// set status only under input enable; a same-cycle clear loses to an edge.
module gpio_edge_det #(
    parameter int            NP       = 32,
    parameter logic [NP-1:0] RSV_MASK = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] pad_in,
    input  logic [NP-1:0] in_en,
    input  logic [NP-1:0] clr_rise,
    input  logic [NP-1:0] clr_fall,
    output logic [NP-1:0] pad_sync,
    output logic [NP-1:0] rise_q,
    output logic [NP-1:0] fall_q
);
    logic [NP-1:0] sync1, sync2, prev;
    logic [NP-1:0] rise_ev, fall_ev;

    // Synchroniser chain plus previous-level flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= pad_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Edge events on the synchronised level, gated and masked
    always_comb begin
        rise_ev = sync2 & ~prev & in_en & ~RSV_MASK;
        fall_ev = ~sync2 & prev & in_en & ~RSV_MASK;
    end

    // Status capture with write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            rise_q <= (rise_q & ~clr_rise) | rise_ev;
            fall_q <= (fall_q & ~clr_fall) | fall_ev;
        end
    end

    assign pad_sync = sync2;
endmodule

// File: rtl/gpio_pad_mux.sv
// Module: per-pin pad driver selection.
// Priority: alternate A, alternate B, output value under output enable,
// otherwise the pad floats (enable 0, level 0).
module gpio_pad_mux #(
    parameter int NP = 32
) (
    input  logic [NP-1:0] out_val,
    input  logic [NP-1:0] out_en,
    input  logic [NP-1:0] sel_a,
    input  logic [NP-1:0] sel_b,
    input  logic [NP-1:0] src_a,
    input  logic [NP-1:0] src_b,
    output logic [NP-1:0] pad_out,
    output logic [NP-1:0] pad_oe
);
    for (genvar i = 0; i < NP; i++) begin : g_pin
        // Pick the driver of pin i
        always_comb begin
            if (sel_a[i]) begin
                pad_out[i] = src_a[i];
                pad_oe[i]  = 1'b1;
            end else if (sel_b[i]) begin
                pad_out[i] = src_b[i];
                pad_oe[i]  = 1'b1;
            end else if (out_en[i]) begin
                pad_out[i] = out_val[i];
                pad_oe[i]  = 1'b1;
            end else begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/gpio_atomic_bank.sv
// Module: top of the GPIO bank. Decodes the two bank windows, hosts six
// atomic control registers, the edge detector and the pad multiplexer.
// Assumes single-cycle writes and a combinational read of bus_addr.
module gpio_atomic_bank #(
    parameter int                   BANK_W    = 16,
    parameter int                   ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]    HIGH_BASE = 8'h80,
    parameter logic [2*BANK_W-1:0]  RSV_MASK  = 32'hE080_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [2*BANK_W-1:0]  bus_wdata,
    output logic [2*BANK_W-1:0]  bus_rdata,
    input  logic [2*BANK_W-1:0]  pad_in,
    output logic [2*BANK_W-1:0]  pad_out,
    output logic [2*BANK_W-1:0]  pad_oe,
    input  logic [2*BANK_W-1:0]  alt_src_a,
    input  logic [2*BANK_W-1:0]  alt_src_b,
    output logic [2*BANK_W-1:0]  alt_in
);
    import gpio_pkg::*;

    localparam int NP = 2 * BANK_W;

    logic              is_hi;
    logic [ADDR_W-1:0] ofs;
    logic [NP-1:0]     ctrl_q [NUM_CTRL];
    logic [NP-1:0]     out_val_q, out_en_q, in_en_q, aux_a_q, aux_b_q, in_alt_q;
    logic [NP-1:0]     pad_sync, rise_q, fall_q;
    logic [NP-1:0]     clr_rise, clr_fall, bank_clr;

    // Window decode: high bank at HIGH_BASE and above
    always_comb begin
        is_hi = (bus_addr >= HIGH_BASE);
        ofs   = is_hi ? (bus_addr - HIGH_BASE) : bus_addr;
    end

    for (genvar f = 0; f < NUM_CTRL; f++) begin : g_ctrl
        logic hit;
        assign hit = bus_wr && (ofs == ADDR_W'(f * REG_STRIDE));
        gpio_ctrl_reg #(.BANK_W(BANK_W), .RSV_MASK(RSV_MASK)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (hit && !is_hi),
            .wr_hi (hit && is_hi),
            .wdata (bus_wdata),
            .q     (ctrl_q[f])
        );
    end

    assign out_val_q = ctrl_q[FN_OUT_VAL];
    assign out_en_q  = ctrl_q[FN_OUT_EN];
    assign in_en_q   = ctrl_q[FN_IN_EN];
    assign aux_a_q   = ctrl_q[FN_ALT_A];
    assign aux_b_q   = ctrl_q[FN_ALT_B];
    assign in_alt_q  = ctrl_q[FN_IN_ALT];

    // Write-one-to-clear masks placed in the addressed bank
    always_comb begin
        bank_clr = is_hi ? {bus_wdata[BANK_W-1:0], {BANK_W{1'b0}}}
                         : {{BANK_W{1'b0}}, bus_wdata[BANK_W-1:0]};
        clr_rise = (bus_wr && ofs == ADDR_W'(OFS_RISE)) ? bank_clr : '0;
        clr_fall = (bus_wr && ofs == ADDR_W'(OFS_FALL)) ? bank_clr : '0;
    end

    gpio_edge_det #(.NP(NP), .RSV_MASK(RSV_MASK)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .in_en    (in_en_q),
        .clr_rise (clr_rise),
        .clr_fall (clr_fall),
        .pad_sync (pad_sync),
        .rise_q   (rise_q),
        .fall_q   (fall_q)
    );

    gpio_pad_mux #(.NP(NP)) u_pad (
        .out_val (out_val_q),
        .out_en  (out_en_q),
        .sel_a   (aux_a_q),
        .sel_b   (aux_b_q),
        .src_a   (alt_src_a),
        .src_b   (alt_src_b),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // Gated synchronised level to alternate-input consumers
    assign alt_in = pad_sync & in_en_q & in_alt_q & ~RSV_MASK;

    // Read mux: pick the full-width source, then expose the addressed bank
    always_comb begin
        logic [NP-1:0] src;
        src = '0;
        for (int f = 0; f < NUM_CTRL; f++) begin
            if (ofs == ADDR_W'(f * REG_STRIDE)) src = ctrl_q[f];
        end
        if (ofs == ADDR_W'(OFS_LEVEL)) src = pad_sync & ~RSV_MASK;
        if (ofs == ADDR_W'(OFS_RISE))  src = rise_q;
        if (ofs == ADDR_W'(OFS_FALL))  src = fall_q;
        bus_rdata = {{BANK_W{1'b0}}, (is_hi ? src[NP-1:BANK_W] : src[BANK_W-1:0])};
    end
endmodule

// File: rtl/gpio_atomic_bank_chk.sv
// Module: property checker for the GPIO bank, bound to the top module.
// Assumes the output-value register sits at offset 0 of the low window.
module gpio_atomic_bank_chk #(
    parameter int                  BANK_W   = 16,
    parameter int                  ADDR_W   = 8,
    parameter logic [2*BANK_W-1:0] RSV_MASK = '0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                wd_set0,
    input logic                wd_clr0,
    input logic [2*BANK_W-1:0] pad_oe,
    input logic [2*BANK_W-1:0] out_val_q,
    input logic [2*BANK_W-1:0] out_en_q,
    input logic [2*BANK_W-1:0] in_en_q,
    input logic [2*BANK_W-1:0] aux_a_q,
    input logic [2*BANK_W-1:0] aux_b_q,
    input logic [2*BANK_W-1:0] rise_q,
    input logic [2*BANK_W-1:0] fall_q
);
    logic pin0_wr;
    assign pin0_wr = bus_wr && (bus_addr == '0);

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (out_val_q == '0 && out_en_q == '0 && rise_q == '0 && fall_q == '0 && pad_oe == '0)); // R1
    AST_SET_PIN0: assert property (@(posedge clk) disable iff (!rst_n)
        pin0_wr && wd_set0 && !wd_clr0 |=> out_val_q[0]); // R2
    AST_CLEAR_PIN0: assert property (@(posedge clk) disable iff (!rst_n)
        pin0_wr && wd_clr0 |=> !out_val_q[0]); // R3
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pin0_wr && wd_set0 && wd_clr0 |=> !out_val_q[0]); // R4
    AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_val_q | out_en_q | in_en_q | aux_a_q | aux_b_q | rise_q | fall_q | pad_oe) & RSV_MASK) == '0); // R5
    AST_PAD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~(out_en_q | aux_a_q | aux_b_q)) == '0); // R6
    AST_EDGE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_q & ~$past(rise_q) & ~$past(in_en_q)) | (fall_q & ~$past(fall_q) & ~$past(in_en_q))) == '0); // R8
endmodule

bind gpio_atomic_bank gpio_atomic_bank_chk #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .RSV_MASK(RSV_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wd_set0   (bus_wdata[0]),
    .wd_clr0   (bus_wdata[BANK_W]),
    .pad_oe    (pad_oe),
    .out_val_q (out_val_q),
    .out_en_q  (out_en_q),
    .in_en_q   (in_en_q),
    .aux_a_q   (aux_a_q),
    .aux_b_q   (aux_b_q),
    .rise_q    (rise_q),
    .fall_q    (fall_q)
);

// File: tb/gpio_atomic_bank_tb.sv
`timescale 1ns/1ps
module gpio_atomic_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, alt_in;
    logic [31:0] alt_src_a = '0;
    logic [31:0] alt_src_b = '0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_atomic_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_src_a(alt_src_a),
        .alt_src_b(alt_src_b), .alt_in(alt_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int k = 0; k < 9; k++) begin
            rd(8'(k * 4), v);        chk("R1 low reg", v, 32'h0);
            rd(8'(k * 4 + 'h80), v); chk("R1 high reg", v, 32'h0);
        end
        chk("R1 pad_oe", pad_oe, 32'h0);
    endtask

    task automatic t_set_clear;
        logic [31:0] v;
        wr(8'h00, 32'h0000_00A5); rd(8'h00, v); chk("R2 set", v, 32'h0000_00A5);
        wr(8'h00, 32'h0000_0102); rd(8'h00, v); chk("R2 set keeps others", v, 32'h0000_01A7);
        wr(8'h00, 32'h0021_0000); rd(8'h00, v); chk("R3 clear", v, 32'h0000_0186);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        wr(8'h04, 32'h0008_0008); rd(8'h04, v); chk("R4 both from 0", v, 32'h0);
        wr(8'h04, 32'h0000_0008); rd(8'h04, v); chk("R4 setup", v, 32'h8);
        wr(8'h04, 32'h0008_0008); rd(8'h04, v); chk("R4 clear wins", v, 32'h0);
    endtask

    task automatic t_high;
        logic [31:0] v;
        wr(8'h80, 32'h0000_0011);
        rd(8'h80, v); chk("R2 high bank", v, 32'h11);
        rd(8'h00, v); chk("R2 low untouched", v, 32'h186);
    endtask

    task automatic t_reserved;
        logic [31:0] v;
        wr(8'h84, 32'h0000_FFFF);
        rd(8'h84, v); chk("R5 reserved read 0", v, 32'h0000_1F7F);
        chk("R5 pad_oe reserved", pad_oe & 32'hE080_0000, 32'h0);
        chk("R6 high oe drives", pad_oe & 32'h1F7F_0000, 32'h1F7F_0000);
        wr(8'h84, 32'hFFFF_0000);
        rd(8'h84, v); chk("R3 high clear all", v, 32'h0);
    endtask

    task automatic t_pad_mux;
        wr(8'h04, 32'h0000_0006);
        tick(1);
        chk("R6 oe pins", pad_oe & 32'hFF, 32'h06);
        chk("R6 drive value", pad_out & 32'h6, 32'h6);
        wr(8'h0C, 32'h0000_0002);
        wr(8'h10, 32'h0000_0004);
        tick(1);
        chk("R6 alt A src 0", pad_out & 32'h2, 32'h0);
        chk("R6 alt B src 0", pad_out & 32'h4, 32'h0);
        wr(8'h10, 32'h0000_0002);
        alt_src_a = 32'h2; alt_src_b = 32'h0;
        tick(1);
        chk("R6 A over B", pad_out & 32'h2, 32'h2);
        wr(8'h04, 32'h0006_0000);
        wr(8'h0C, 32'h0002_0000);
        wr(8'h10, 32'h0006_0000);
        tick(1);
        chk("R6 float", pad_oe, 32'h0);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        pad_in = 32'h1234_5678; tick(3);
        rd(8'h18, v); chk("R7 low level", v, 32'h5678);
        rd(8'h98, v); chk("R7 high level", v, 32'h1234);
        pad_in = 32'h00FF_0000; tick(3);
        rd(8'h98, v); chk("R7 reserved level", v, 32'h007F);
    endtask

    task automatic t_edges;
        logic [31:0] v;
        pad_in = 32'h0; tick(4);
        wr(8'h08, 32'h0000_0003);
        wr(8'h88, 32'h0000_0001);
        pad_in = 32'h0001_0007; tick(4);
        rd(8'h1C, v); chk("R8 rise gated", v, 32'h3);
        rd(8'h9C, v); chk("R8 rise high", v, 32'h1);
        rd(8'h20, v); chk("R8 no fall", v, 32'h0);
        pad_in = 32'h0001_0002; tick(4);
        rd(8'h20, v); chk("R8 fall", v, 32'h1);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(8'h1C, 32'hFFFF_0002);
        rd(8'h1C, v); chk("R9 w1c one pin", v, 32'h1);
        wr(8'h1C, 32'h0000_0001);
        rd(8'h1C, v); chk("R9 w1c last", v, 32'h0);
        rd(8'h9C, v); chk("R9 other bank kept", v, 32'h1);
    endtask

    task automatic t_alt_in;
        wr(8'h14, 32'h0000_0001);
        pad_in = 32'h0001_0003; tick(3);
        chk("R10 alt_in on", alt_in & 32'h3, 32'h1);
        wr(8'h08, 32'h0001_0000);
        tick(1);
        chk("R10 alt_in gated", alt_in & 32'h3, 32'h0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_set_clear();
        t_priority();
        t_high();
        t_reserved();
        t_pad_mux();
        t_readback();
        t_edges();
        t_w1c();
        t_alt_in();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule